// File: doc/BRIEF.md
# Voxel Bit-Plane Transposer

The block collects groups of sixteen colour voxels from a valid/ready input stream and re-emits each group as a run of bit-plane words for an LED driver that takes reduced-depth grayscale data plane by plane. Every voxel carries a red, a green and a blue value of 9 bits each. A word holds one bit from every colour of every LED in the group, so a group leaves as nine 48-bit words, 432 bits in all.

Output is plane-major, not pixel-major. The most significant plane of all sixteen LEDs goes out before any LED's next bit. Nothing can be sent until the whole group is held. Two group buffers alternate: one fills from the input while the other drains to the output. The input stalls only when both buffers hold complete groups that are still waiting to be sent.

Top module: `vox_xpose`

## Requirements
- R1: A voxel (in_red, in_grn, in_blu, each 9 bits) is taken when in_valid and in_ready are both high at a rising clock edge. The n-th voxel taken within a group becomes LED n, for n from 0 to 15.
- R2: out_valid stays low until all 16 voxels of a group have been taken. It rises in the cycle after the edge that takes the 16th voxel, provided a buffer was free to drain.
- R3: Each group produces exactly 9 output words in descending plane order. The first word carries bit 8 of every channel, and each later word carries the next lower bit, down to bit 0.
- R4: In a word for plane p, bit 3k+2 is bit p of LED k's red, bit 3k+1 is bit p of its green, and bit 3k is bit p of its blue, for k from 0 to 15.
- R5: out_last is high on the ninth word of a group (plane 0) and low on the other eight.
- R6: While out_valid is high and out_ready is low, out_data and out_last hold their values and out_valid stays high.
- R7: in_ready is low exactly when both buffers hold complete groups not yet fully sent. After reset, in_ready is high and out_valid is low.
- R8: A second group can be taken in full while the first is still unsent, and neither group's data is altered by the other.
- R9: Groups leave in the order in which they were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Voxel offered |
| in_ready | output | 1 | Block can take a voxel |
| in_red | input | 9 | Red value of the offered voxel |
| in_grn | input | 9 | Green value of the offered voxel |
| in_blu | input | 9 | Blue value of the offered voxel |
| out_valid | output | 1 | Plane word offered |
| out_ready | input | 1 | Consumer takes the plane word |
| out_data | output | 48 | Plane word, layout per R4 |
| out_last | output | 1 | Word is the final plane of its group |

## Verification
A stuck or skipped plane counter shows up as a wrong word, or a misplaced out_last, within one accepted output word. A wrong LED index on the fill side garbles the first word of the group it belongs to, which is visible as soon as the group starts draining. An occupancy flag that is set or cleared at the wrong time shows either as out_valid rising before the 16th voxel is taken, or as in_ready staying high while two full groups wait. Both show in the cycle right after the edge that caused them. A buffer select that toggles wrongly sends the groups in the wrong order, or sends a stale group. This is seen on the first word of the following group.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
  localparam int unsigned DEF_LEDS  = 16;
  localparam int unsigned DEF_DEPTH = 9;
  localparam int unsigned NCOL      = 3;

  // position of colour col (0 red, 1 green, 2 blue) of LED led inside a plane word
  function automatic int unsigned plane_pos(input int unsigned led, input int unsigned col);
    return led * NCOL + (NCOL - 1 - col);
  endfunction
endpackage

// File: rtl/vbp_bank.sv
module vbp_bank #(
  parameter int unsigned LEDS  = vbp_pkg::DEF_LEDS,
  parameter int unsigned DEPTH = vbp_pkg::DEF_DEPTH,
  localparam int unsigned IW   = $clog2(LEDS),
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned WW   = LEDS * vbp_pkg::NCOL
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [DEPTH-1:0] wr,
  input  logic [DEPTH-1:0] wg,
  input  logic [DEPTH-1:0] wb,
  input  logic [PW-1:0]    plane,
  output logic [WW-1:0]    word
);
  logic [DEPTH-1:0] red_q [LEDS];
  logic [DEPTH-1:0] grn_q [LEDS];
  logic [DEPTH-1:0] blu_q [LEDS];

  always_ff @(posedge clk) begin
    if (we) begin
      red_q[waddr] <= wr;
      grn_q[waddr] <= wg;
      blu_q[waddr] <= wb;
    end
  end

  for (genvar k = 0; k < LEDS; k++) begin : g_led
    always_comb begin
      word[vbp_pkg::plane_pos(k, 0)] = red_q[k][plane];
      word[vbp_pkg::plane_pos(k, 1)] = grn_q[k][plane];
      word[vbp_pkg::plane_pos(k, 2)] = blu_q[k][plane];
    end
  end
endmodule

// File: rtl/vbp_fill.sv
module vbp_fill #(
  parameter int unsigned LEDS = vbp_pkg::DEF_LEDS,
  localparam int unsigned IW  = $clog2(LEDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_fire,
  output logic          wsel,
  output logic [IW-1:0] widx,
  output logic          group_done
);
  localparam logic [IW-1:0] LAST_IDX = IW'(LEDS - 1);

  assign group_done = in_fire && (widx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx <= '0;
      wsel <= 1'b0;
    end else if (in_fire) begin
      if (group_done) begin
        widx <= '0;
        wsel <= ~wsel;
      end else begin
        widx <= widx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbp_drain.sv
module vbp_drain #(
  parameter int unsigned DEPTH = vbp_pkg::DEF_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_fire,
  output logic          rsel,
  output logic [PW-1:0] plane,
  output logic          is_last,
  output logic          drain_done
);
  localparam logic [PW-1:0] TOP_PLANE = PW'(DEPTH - 1);

  assign is_last    = (plane == '0);
  assign drain_done = out_fire && is_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plane <= TOP_PLANE;
      rsel  <= 1'b0;
    end else if (out_fire) begin
      if (is_last) begin
        plane <= TOP_PLANE;
        rsel  <= ~rsel;
      end else begin
        plane <= plane - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vox_xpose.sv
module vox_xpose #(
  parameter int unsigned LEDS  = vbp_pkg::DEF_LEDS,
  parameter int unsigned DEPTH = vbp_pkg::DEF_DEPTH,
  localparam int unsigned IW   = $clog2(LEDS),
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned WW   = LEDS * vbp_pkg::NCOL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DEPTH-1:0] in_red,
  input  logic [DEPTH-1:0] in_grn,
  input  logic [DEPTH-1:0] in_blu,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WW-1:0]    out_data,
  output logic             out_last
);
  logic          wsel, rsel, group_done, drain_done, is_last;
  logic          in_fire, out_fire;
  logic [IW-1:0] widx;
  logic [PW-1:0] plane;
  logic [1:0]    full_q;
  logic [WW-1:0] bank_word [2];

  assign in_ready  = ~full_q[wsel];
  assign in_fire   = in_valid && in_ready;
  assign out_valid = full_q[rsel];
  assign out_fire  = out_valid && out_ready;
  assign out_data  = bank_word[rsel];
  assign out_last  = is_last;

  vbp_fill #(.LEDS(LEDS)) u_fill (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire),
    .wsel(wsel), .widx(widx), .group_done(group_done)
  );

  vbp_drain #(.DEPTH(DEPTH)) u_drain (
    .clk(clk), .rst_n(rst_n), .out_fire(out_fire),
    .rsel(rsel), .plane(plane), .is_last(is_last), .drain_done(drain_done)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    vbp_bank #(.LEDS(LEDS), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .we(in_fire && (wsel == 1'(b))), .waddr(widx),
      .wr(in_red), .wg(in_grn), .wb(in_blu),
      .plane(plane), .word(bank_word[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)
        full_q[b] <= 1'b0;
      else if (group_done && (wsel == 1'(b)))
        full_q[b] <= 1'b1;
      else if (drain_done && (rsel == 1'(b)))
        full_q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/vox_xpose_chk.sv
module vox_xpose_chk #(
  parameter int unsigned LEDS  = vbp_pkg::DEF_LEDS,
  parameter int unsigned DEPTH = vbp_pkg::DEF_DEPTH,
  localparam int unsigned WW   = LEDS * vbp_pkg::NCOL
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [WW-1:0] out_data,
  input logic          out_last,
  input logic          group_done,
  input logic          drain_done
);
  localparam int unsigned IW = $clog2(LEDS);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [1:0]    pend;
  logic [IW-1:0] acc;
  logic [PW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      acc  <= '0;
      wcnt <= '0;
    end else begin
      pend <= pend + {1'b0, group_done} - {1'b0, drain_done};
      if (in_valid && in_ready)
        acc <= (acc == IW'(LEDS - 1)) ? '0 : acc + 1'b1;
      if (out_valid && out_ready)
        wcnt <= (wcnt == PW'(DEPTH - 1)) ? '0 : wcnt + 1'b1;
    end
  end

  // R7
  ready_vs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (pend != 2'd2));

  // R2
  no_early_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend != 2'd0));

  // R2
  group_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    group_done == (in_valid && in_ready && (acc == IW'(LEDS - 1))));

  // R5
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (wcnt == PW'(DEPTH - 1))));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind vox_xpose vox_xpose_chk #(.LEDS(LEDS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .group_done(group_done), .drain_done(drain_done)
);

// File: tb/vox_xpose_bench.sv
module vox_xpose_bench;
  localparam int L = 16;
  localparam int D = 9;
  localparam int W = 48;

  // each entry: [15:8] seed of the group data, [7:0] planes (bit p) that get a stall
  localparam logic [15:0] VEC [4] = '{16'h00_00, 16'h5A_81, 16'hC3_3C, 16'hFF_FF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [D-1:0] in_red = '0, in_grn = '0, in_blu = '0;
  logic in_ready, out_valid, out_last;
  logic [W-1:0] out_data;

  int total = 0, bad = 0;
  logic [D-1:0] vr [2][L];
  logic [D-1:0] vg [2][L];
  logic [D-1:0] vb [2][L];

  always #10 clk = ~clk;

  vox_xpose u_vox_xpose (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected word for plane p: walk the word bit by bit, derive LED and colour
  function automatic logic [W-1:0] exp_word(input int s, input int p);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) begin
      int led = i / 3;
      case (i % 3)
        2: w[i] = vr[s][led][p];
        1: w[i] = vg[s][led][p];
        default: w[i] = vb[s][led][p];
      endcase
    end
    return w;
  endfunction

  task automatic load_seed(input int s, input logic [7:0] seed);
    for (int k = 0; k < L; k++) begin
      vr[s][k] = D'((seed * 37 + k * 113) ^ (k << 5));
      vg[s][k] = D'((seed * 91 + k * 29) ^ 9'h0A5);
      vb[s][k] = D'((seed * 13 + k * 201) ^ (k * 7));
    end
  endtask

  task automatic push_group(input int s, input bit watch_early);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_red = vr[s][k]; in_grn = vg[s][k]; in_blu = vb[s][k];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (watch_early && k < L - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 no word before group complete", W'(out_valid), W'(0));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_group(input int s, input logic [7:0] stall);
    for (int p = D - 1; p >= 0; p--) begin
      @(negedge clk);
      out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      if (p < 8 && stall[p]) begin
        logic [W-1:0] held;
        logic hl;
        held = out_data; hl = out_last;
        repeat (2) @(negedge clk);
        check("R6 data held during stall", out_data, held);
        check("R6 last/valid held during stall", W'({out_valid, out_last}), W'({1'b1, hl}));
      end
      out_ready = 1'b1;
      check("R3 R4 R9 plane word", out_data, exp_word(s, p));
      check("R5 last flag", W'(out_last), W'(p == 0));
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    check("R7 in_ready after reset", W'(in_ready), W'(1));
    check("R7 out_valid after reset", W'(out_valid), W'(0));

    // table walk: one group per entry, R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 4; v++) begin
      load_seed(0, VEC[v][15:8]);
      push_group(0, 1'b1);
      check("R2 word offered after 16th voxel", W'(out_valid), W'(1));
      pop_group(0, VEC[v][7:0]);
    end

    // corner: single set bits at both word ends (R4 R1)
    for (int k = 0; k < L; k++) begin
      vr[0][k] = '0; vg[0][k] = '0; vb[0][k] = '0;
    end
    vr[0][L-1] = 9'h100;
    vb[0][0]   = 9'h001;
    push_group(0, 1'b1);
    @(negedge clk);
    check("R4 top plane only LED15 red", out_data, {1'b1, 47'b0});
    pop_group(0, 8'h00);

    // double buffering: two groups, no draining, then input must stall (R7 R8)
    load_seed(0, 8'h21);
    load_seed(1, 8'h9E);
    push_group(0, 1'b0);
    push_group(1, 1'b0);
    @(negedge clk);
    check("R7 in_ready low with both buffers full", W'(in_ready), W'(0));
    in_valid = 1'b1; in_red = '1; in_grn = '1; in_blu = '1;
    repeat (3) @(negedge clk);
    check("R7 in_ready still low while offered", W'(in_ready), W'(0));
    in_valid = 1'b0;
    pop_group(0, 8'h10);
    check("R8 in_ready back high after one group drained", W'(in_ready), W'(1));
    pop_group(1, 8'h00);
    check("R9 idle after both groups", W'(out_valid), W'(0));

    // overlap: fill next group while the current one drains (R8 R9)
    load_seed(0, 8'h44);
    load_seed(1, 8'h77);
    push_group(0, 1'b0);
    fork
      pop_group(0, 8'h06);
      push_group(1, 1'b0);
    join
    pop_group(1, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule